// File: doc/BRIEF.md
# Registered RV32I Control Decoder

This block turns the fields of a base-integer instruction that select its behaviour into the single-bit control flags a small serial or multi-cycle core needs. It looks at nine instruction bits only: bit 30, the three funct3 bits and opcode bits [6:2]. These bits form a nine-bit index, `{bit30, funct3[2:0], opcode[6:2]}`, which has 512 possible values. Every index is classified as one of the 37 base integer instructions or as unlisted. The flag vector for that class is computed combinationally.

The flags are captured on the rising clock edge when the enable is high. They then hold until the next enabled edge, so the core can load a new instruction and keep its controls steady over many cycles. A synchronous active-high reset clears every flag and takes priority over the enable. Three pairs of flags are never needed at the same time, so each pair shares one register and comes out on two ports: the parent port and an alias port.

Top module: `rvi_ctrl_decode`

## Requirements
- R1: Input bit 30 changes the decode only for ADD/SUB (OP, funct3 000), SRL/SRA (OP, funct3 101) and SRLI/SRAI (OP-IMM, funct3 101). In those cases bit 30 = 1 selects SUB, SRA and SRAI. It also marks OP encodings with any other funct3, and OP-IMM with funct3 001, as unlisted. For every other instruction its value has no effect on any output.
- R2: With `en` low and `rst` low, every output keeps its value across a clock edge. With `en` high, the outputs show the decode of the inputs present at that edge, one cycle later.
- R3: With `rst` high at a clock edge, every output is 0 after that edge, whatever `en` is.
- R4: `o_mem_op` is 1 for loads (opcode 00000; funct3 000, 001, 010, 100, 101) and stores (opcode 01000; funct3 000, 001, 010). It is 0 for every other instruction.
- R5: `o_branch_op` is 1 for JAL (11011), JALR (11001) and the six conditional branches (opcode 11000; funct3 000, 001, 100, 101, 110, 111).
- R6: `o_shift_op` is 1 for SLLI, SRLI, SRAI, SLL, SRL and SRA (funct3 001/101 under OP-IMM 00100 or OP 01100). `o_slt_op` is 1 for SLTI, SLTIU, SLT and SLTU (funct3 010/011 under the same opcodes).
- R7: `o_two_stage` is 1 for jumps, branches, loads, stores, SLTI, SLTIU, the three immediate shifts, SLL, SLT, SLTU, SRL and SRA. It is 0 for LUI (01101), AUIPC (00101), ADDI, XORI, ORI, ANDI, ADD, SUB, XOR, OR and AND.
- R8: `o_rd_write` is 1 for every listed instruction except the stores and the conditional branches.
- R9: Access size and sign apply to loads and stores only. `o_mem_word` is 1 when funct3[1:0] = 10. `o_mem_half` is 1 when funct3[1:0] = 01. `o_mem_signed` is 1 for LB and LH only.
- R10: `o_alu_sub` is 1 for SUB, SLT, SLTU, SLTI, SLTIU, the six conditional branches, AND and ANDI. `o_bool_hi` always equals `o_alu_sub`.
- R11: `o_cmp_eq` is 1 for BEQ, BNE, OR, ORI, AND and ANDI. `o_bool_lo` always equals `o_cmp_eq`.
- R12: `o_bne_or_bge` is 1 for BNE, BGE, BGEU, JAL and JALR. `o_jump` always equals `o_bne_or_bge`.
- R13: Any index that matches none of the 37 listed instructions drives every output to 0. This includes opcodes 00011 and 11100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Capture enable for the decoded flags |
| i_b30 | input | 1 | Instruction bit 30 |
| i_funct3 | input | 3 | Instruction funct3 field |
| i_opcode | input | 5 | Instruction opcode bits [6:2] |
| o_mem_op | output | 1 | Load or store |
| o_branch_op | output | 1 | Jump or conditional branch |
| o_shift_op | output | 1 | Shift instruction |
| o_slt_op | output | 1 | Set-less-than instruction |
| o_two_stage | output | 1 | Instruction needs a second execution phase |
| o_rd_write | output | 1 | Destination register is written |
| o_mem_word | output | 1 | Word access |
| o_mem_half | output | 1 | Halfword access |
| o_mem_signed | output | 1 | Sign-extending load |
| o_alu_sub | output | 1 | ALU subtracts |
| o_bool_hi | output | 1 | Boolean-op select high bit (alias of o_alu_sub) |
| o_cmp_eq | output | 1 | Comparison tests equality |
| o_bool_lo | output | 1 | Boolean-op select low bit (alias of o_cmp_eq) |
| o_bne_or_bge | output | 1 | Inverted branch condition |
| o_jump | output | 1 | JAL or JALR (alias of o_bne_or_bge) |

## Verification
The bench sweeps all 512 index values and compares every port with a table it builds from the instruction list. That sweep catches several kinds of error:
- A decoder that ignores bit 30 would treat SUB as ADD or SRA as SRL. One that over-uses bit 30 would lose ADDI-like instructions with bit 30 set.
- A decoder that fills the holes would raise flags for the branch funct3 values 010/011, for the unused load funct3 values, or for fence and system opcodes.

The bench also stresses how the registers behave in time:
- It changes the inputs while `en` is low. A flop that ignores the enable would let the new decode through.
- It asserts reset together with the enable. A reset placed below the enable in priority would load the new decode instead of zeros.

// File: rtl/rvi_ctrl_pkg.sv
package rvi_ctrl_pkg;

  localparam int OPC_W = 5;
  localparam int F3_W  = 3;
  localparam int IDX_W = 1 + F3_W + OPC_W;

  localparam logic [OPC_W-1:0] OPC_LUI    = 5'b01101;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 5'b00101;
  localparam logic [OPC_W-1:0] OPC_JAL    = 5'b11011;
  localparam logic [OPC_W-1:0] OPC_JALR   = 5'b11001;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 5'b11000;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 5'b00000;
  localparam logic [OPC_W-1:0] OPC_STORE  = 5'b01000;
  localparam logic [OPC_W-1:0] OPC_OPIMM  = 5'b00100;
  localparam logic [OPC_W-1:0] OPC_OP     = 5'b01100;

  typedef enum logic [3:0] {
    CLS_NONE, CLS_LUI, CLS_AUIPC, CLS_JAL, CLS_JALR,
    CLS_BRANCH, CLS_LOAD, CLS_STORE, CLS_OPIMM, CLS_OP
  } cls_e;

  typedef struct packed {
    logic mem_op;
    logic branch_op;
    logic shift_op;
    logic slt_op;
    logic two_stage;
    logic rd_write;
    logic mem_word;
    logic mem_half;
    logic mem_signed;
    logic alu_sub;     // shared with boolean-op high bit
    logic cmp_eq;      // shared with boolean-op low bit
    logic bne_or_bge;  // shared with jump flag
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Opcode to instruction group.
  function automatic cls_e cls_of(logic [OPC_W-1:0] opc);
    case (opc)
      OPC_LUI:    return CLS_LUI;
      OPC_AUIPC:  return CLS_AUIPC;
      OPC_JAL:    return CLS_JAL;
      OPC_JALR:   return CLS_JALR;
      OPC_BRANCH: return CLS_BRANCH;
      OPC_LOAD:   return CLS_LOAD;
      OPC_STORE:  return CLS_STORE;
      OPC_OPIMM:  return CLS_OPIMM;
      OPC_OP:     return CLS_OP;
      default:    return CLS_NONE;
    endcase
  endfunction

  // Whether funct3 and bit 30 name a listed instruction in the group.
  function automatic logic legal(cls_e c, logic [F3_W-1:0] f3, logic b30);
    case (c)
      CLS_LUI, CLS_AUIPC, CLS_JAL, CLS_JALR: return 1'b1;
      CLS_BRANCH: return f3[2:1] != 2'b01;
      CLS_LOAD:   return (f3 != 3'b011) && (f3[2:1] != 2'b11);
      CLS_STORE:  return !f3[2] && (f3[1:0] != 2'b11);
      CLS_OPIMM:  return !((f3 == 3'b001) && b30);
      CLS_OP:     return !b30 || (f3 == 3'b000) || (f3 == 3'b101);
      default:    return 1'b0;
    endcase
  endfunction

  // Flag vector of a listed instruction.
  function automatic ctrl_t flags_of(cls_e c, logic [F3_W-1:0] f3, logic b30);
    ctrl_t r;
    logic  ari, ldst;
    ari  = (c == CLS_OPIMM) || (c == CLS_OP);
    ldst = (c == CLS_LOAD) || (c == CLS_STORE);
    r = '0;
    r.mem_op     = ldst;
    r.branch_op  = (c == CLS_JAL) || (c == CLS_JALR) || (c == CLS_BRANCH);
    r.shift_op   = ari && (f3[1:0] == 2'b01);
    r.slt_op     = ari && (f3[2:1] == 2'b01);
    r.two_stage  = r.mem_op || r.branch_op || r.shift_op || r.slt_op;
    r.rd_write   = (c != CLS_STORE) && (c != CLS_BRANCH) && (c != CLS_NONE);
    r.mem_word   = ldst && (f3[1:0] == 2'b10);
    r.mem_half   = ldst && (f3[1:0] == 2'b01);
    r.mem_signed = (c == CLS_LOAD) && !f3[2] && !f3[1];
    r.alu_sub    = (c == CLS_BRANCH) || r.slt_op || (ari && f3 == 3'b111)
                 || ((c == CLS_OP) && b30 && f3 == 3'b000);
    r.cmp_eq     = ((c == CLS_BRANCH) && f3[2:1] == 2'b00)
                 || (ari && f3[2:1] == 2'b11);
    r.bne_or_bge = (c == CLS_JAL) || (c == CLS_JALR)
                 || ((c == CLS_BRANCH) && f3[0]);
    return r;
  endfunction

endpackage

// File: rtl/rvi_ctrl_classify.sv
module rvi_ctrl_classify
  import rvi_ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [F3_W-1:0]  funct3,
  input  logic             b30,
  output cls_e             cls,
  output logic             valid
);

  cls_e grp;

  always_comb begin
    grp   = cls_of(opcode);
    valid = legal(grp, funct3, b30);
    cls   = valid ? grp : CLS_NONE;
  end

endmodule

// File: rtl/rvi_ctrl_flags.sv
module rvi_ctrl_flags
  import rvi_ctrl_pkg::*;
(
  input  cls_e             cls,
  input  logic             valid,
  input  logic [F3_W-1:0]  funct3,
  input  logic             b30,
  output ctrl_t            flags
);

  always_comb begin
    flags = valid ? flags_of(cls, funct3, b30) : '0;
  end

endmodule

// File: rtl/rvi_ctrl_regs.sv
module rvi_ctrl_regs #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)     q[i] <= 1'b0;
      else if (en) q[i] <= d[i];
    end
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));                                           // R2
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (q == '0));                                            // R3

endmodule

// File: rtl/rvi_ctrl_decode.sv
module rvi_ctrl_decode
  import rvi_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             i_b30,
  input  logic [2:0]       i_funct3,
  input  logic [4:0]       i_opcode,
  output logic             o_mem_op,
  output logic             o_branch_op,
  output logic             o_shift_op,
  output logic             o_slt_op,
  output logic             o_two_stage,
  output logic             o_rd_write,
  output logic             o_mem_word,
  output logic             o_mem_half,
  output logic             o_mem_signed,
  output logic             o_alu_sub,
  output logic             o_bool_hi,
  output logic             o_cmp_eq,
  output logic             o_bool_lo,
  output logic             o_bne_or_bge,
  output logic             o_jump
);

  cls_e  dec_cls;
  logic  dec_valid;
  ctrl_t next_flags;
  ctrl_t held;

  rvi_ctrl_classify u_cls (
    .opcode (i_opcode),
    .funct3 (i_funct3),
    .b30    (i_b30),
    .cls    (dec_cls),
    .valid  (dec_valid)
  );

  rvi_ctrl_flags u_flags (
    .cls    (dec_cls),
    .valid  (dec_valid),
    .funct3 (i_funct3),
    .b30    (i_b30),
    .flags  (next_flags)
  );

  rvi_ctrl_regs #(.W(CTRL_W)) u_regs (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .d   (next_flags),
    .q   (held)
  );

  assign o_mem_op     = held.mem_op;
  assign o_branch_op  = held.branch_op;
  assign o_shift_op   = held.shift_op;
  assign o_slt_op     = held.slt_op;
  assign o_two_stage  = held.two_stage;
  assign o_rd_write   = held.rd_write;
  assign o_mem_word   = held.mem_word;
  assign o_mem_half   = held.mem_half;
  assign o_mem_signed = held.mem_signed;
  assign o_alu_sub    = held.alu_sub;
  assign o_bool_hi    = held.alu_sub;
  assign o_cmp_eq     = held.cmp_eq;
  assign o_bool_lo    = held.cmp_eq;
  assign o_bne_or_bge = held.bne_or_bge;
  assign o_jump       = held.bne_or_bge;

  AST_UNLISTED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (next_flags == '0));                            // R13
  AST_SIZE_NEEDS_MEM: assert property (@(posedge clk) disable iff (rst)
    (next_flags.mem_word || next_flags.mem_half || next_flags.mem_signed)
      |-> next_flags.mem_op);                                      // R9
  AST_GROUPS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $countones({next_flags.mem_op, next_flags.branch_op,
                next_flags.shift_op, next_flags.slt_op}) <= 1);    // R4
  AST_CAPTURE_ON_EN: assert property (@(posedge clk) disable iff (rst)
    en |=> (held == $past(next_flags)));                           // R2

endmodule

// File: tb/rvi_ctrl_decode_test.sv
`timescale 1ns/1ps
module rvi_ctrl_decode_test;

  logic clk = 1'b0;
  logic rst, en, b30;
  logic [2:0] f3;
  logic [4:0] opc;
  logic mem_op, branch_op, shift_op, slt_op, two_stage, rd_write;
  logic mem_word, mem_half, mem_signed, alu_sub, bool_hi, cmp_eq, bool_lo;
  logic bne_or_bge, jump;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rvi_ctrl_decode uut (
    .clk(clk), .rst(rst), .en(en), .i_b30(b30), .i_funct3(f3), .i_opcode(opc),
    .o_mem_op(mem_op), .o_branch_op(branch_op), .o_shift_op(shift_op),
    .o_slt_op(slt_op), .o_two_stage(two_stage), .o_rd_write(rd_write),
    .o_mem_word(mem_word), .o_mem_half(mem_half), .o_mem_signed(mem_signed),
    .o_alu_sub(alu_sub), .o_bool_hi(bool_hi), .o_cmp_eq(cmp_eq),
    .o_bool_lo(bool_lo), .o_bne_or_bge(bne_or_bge), .o_jump(jump)
  );

  typedef struct packed {
    logic mem, br, sh, slt, two, rd, w, h, s, sub, eq, nb;
  } exp_t;

  // Reference built per instruction from the encoding list.
  function automatic exp_t ref_of(logic b, logic [2:0] f, logic [4:0] o);
    exp_t e;
    logic lui, auipc, jal, jalr, beq, bne, blt, bge, bltu, bgeu;
    logic lb, lh, lw, lbu, lhu, sb, sh, sw;
    logic addi, slti, sltiu, xori, ori, andi, slli, srli, srai;
    logic add, sub, sll, slt, sltu, xor_, srl, sra, or_, and_;
    logic oi, op, br;
    lui = (o == 5'b01101); auipc = (o == 5'b00101);
    jal = (o == 5'b11011); jalr = (o == 5'b11001);
    br = (o == 5'b11000);
    beq = br && f == 3'd0; bne = br && f == 3'd1; blt = br && f == 3'd4;
    bge = br && f == 3'd5; bltu = br && f == 3'd6; bgeu = br && f == 3'd7;
    lb  = (o == 5'b00000) && f == 3'd0; lh  = (o == 5'b00000) && f == 3'd1;
    lw  = (o == 5'b00000) && f == 3'd2; lbu = (o == 5'b00000) && f == 3'd4;
    lhu = (o == 5'b00000) && f == 3'd5;
    sb  = (o == 5'b01000) && f == 3'd0; sh  = (o == 5'b01000) && f == 3'd1;
    sw  = (o == 5'b01000) && f == 3'd2;
    oi = (o == 5'b00100); op = (o == 5'b01100);
    addi = oi && f == 3'd0; slti = oi && f == 3'd2; sltiu = oi && f == 3'd3;
    xori = oi && f == 3'd4; ori = oi && f == 3'd6; andi = oi && f == 3'd7;
    slli = oi && f == 3'd1 && !b; srli = oi && f == 3'd5 && !b;
    srai = oi && f == 3'd5 && b;
    add = op && !b && f == 3'd0; sub = op && b && f == 3'd0;
    sll = op && !b && f == 3'd1; slt = op && !b && f == 3'd2;
    sltu = op && !b && f == 3'd3; xor_ = op && !b && f == 3'd4;
    srl = op && !b && f == 3'd5; sra = op && b && f == 3'd5;
    or_ = op && !b && f == 3'd6; and_ = op && !b && f == 3'd7;
    e.mem = lb | lh | lw | lbu | lhu | sb | sh | sw;
    e.br  = jal | jalr | beq | bne | blt | bge | bltu | bgeu;
    e.sh  = slli | srli | srai | sll | srl | sra;
    e.slt = slti | sltiu | slt | sltu;
    e.two = e.br | e.mem | slti | sltiu | slli | srli | srai
          | sll | slt | sltu | srl | sra;
    e.rd  = lui | auipc | jal | jalr | lb | lh | lw | lbu | lhu | addi | slti
          | sltiu | xori | ori | andi | slli | srli | srai | add | sub | sll
          | slt | sltu | xor_ | srl | sra | or_ | and_;
    e.w   = lw | sw;
    e.h   = lh | lhu | sh;
    e.s   = lb | lh;
    e.sub = sub | slt | sltu | slti | sltiu | beq | bne | blt | bge | bltu
          | bgeu | and_ | andi;
    e.eq  = beq | bne | or_ | ori | and_ | andi;
    e.nb  = bne | bge | bgeu | jal | jalr;
    return e;
  endfunction

  task automatic chk(string req, string nm, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("[TB] FAIL %s %s idx=%b_%b_%b actual=%0b expected=%0b",
               req, nm, b30, f3, opc, act, exp);
    end
  endtask

  task automatic chk_all(exp_t e);
    chk("R4", "mem_op", mem_op, e.mem);
    chk("R5", "branch_op", branch_op, e.br);
    chk("R6", "shift_op", shift_op, e.sh);
    chk("R6", "slt_op", slt_op, e.slt);
    chk("R7", "two_stage", two_stage, e.two);
    chk("R8", "rd_write", rd_write, e.rd);
    chk("R9", "mem_word", mem_word, e.w);
    chk("R9", "mem_half", mem_half, e.h);
    chk("R9", "mem_signed", mem_signed, e.s);
    chk("R10", "alu_sub", alu_sub, e.sub);
    chk("R10", "bool_hi", bool_hi, e.sub);
    chk("R11", "cmp_eq", cmp_eq, e.eq);
    chk("R11", "bool_lo", bool_lo, e.eq);
    chk("R12", "bne_or_bge", bne_or_bge, e.nb);
    chk("R12", "jump", jump, e.nb);
  endtask

  task automatic apply(logic b, logic [2:0] f, logic [4:0] o, logic e_n, logic r);
    @(negedge clk);
    b30 = b; f3 = f; opc = o; en = e_n; rst = r;
    @(posedge clk);
    @(negedge clk);
  endtask

  // R3: reset state
  task automatic t_reset;
    apply(1'b0, 3'd2, 5'b00000, 1'b0, 1'b1);
    chk_all('0);
  endtask

  // R1, R4..R13: full index sweep
  task automatic t_sweep;
    for (int i = 0; i < 512; i++) begin
      logic [8:0] x;
      x = 9'(i);
      apply(x[8], x[7:5], x[4:0], 1'b1, 1'b0);
      chk_all(ref_of(x[8], x[7:5], x[4:0]));
    end
  endtask

  // R1: bit 30 has no effect on ADDI, LW and BNE
  task automatic t_bit30;
    apply(1'b1, 3'd0, 5'b00100, 1'b1, 1'b0);
    chk("R1", "addi_b30_rd", rd_write, 1'b1);
    chk("R1", "addi_b30_sub", alu_sub, 1'b0);
    apply(1'b1, 3'd2, 5'b00000, 1'b1, 1'b0);
    chk("R1", "lw_b30_word", mem_word, 1'b1);
    apply(1'b1, 3'd1, 5'b11000, 1'b1, 1'b0);
    chk("R1", "bne_b30_nb", bne_or_bge, 1'b1);
    apply(1'b1, 3'd0, 5'b01100, 1'b1, 1'b0);
    chk("R1", "sub_sel", alu_sub, 1'b1);
  endtask

  // R2: hold while enable is low, then capture
  task automatic t_hold;
    apply(1'b0, 3'd2, 5'b00000, 1'b1, 1'b0);   // LW
    apply(1'b0, 3'd0, 5'b01100, 1'b0, 1'b0);   // ADD presented, en low
    apply(1'b1, 3'd5, 5'b01100, 1'b0, 1'b0);   // SRA presented, en low
    chk("R2", "hold_mem", mem_op, 1'b1);
    chk("R2", "hold_word", mem_word, 1'b1);
    chk("R2", "hold_shift", shift_op, 1'b0);
    apply(1'b1, 3'd5, 5'b01100, 1'b1, 1'b0);
    chk("R2", "cap_shift", shift_op, 1'b1);
    chk("R2", "cap_mem", mem_op, 1'b0);
  endtask

  // R3: reset beats enable
  task automatic t_rst_prio;
    apply(1'b0, 3'd0, 5'b11011, 1'b1, 1'b0);   // JAL
    chk("R3", "pre_jump", jump, 1'b1);
    apply(1'b0, 3'd0, 5'b11011, 1'b1, 1'b1);
    chk("R3", "rst_jump", jump, 1'b0);
    chk("R3", "rst_rd", rd_write, 1'b0);
    chk("R3", "rst_branch", branch_op, 1'b0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      tests++; fails++;
      $display("[TB] FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; en = 1'b0; b30 = 1'b0; f3 = '0; opc = '0;
    t_reset();
    t_sweep();
    t_bit30();
    t_hold();
    t_rst_prio();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule